// File: doc/BRIEF.md
# Soft-Decision Symbol Slicer

This block converts each signed baseband sample on the in-phase and quadrature rails into a 3-bit soft decision for a downstream error-correction decoder. Each decision has a sign bit and a 2-bit confidence value. The confidence is set by three comparison levels. All three levels come from one programmed step value, at one, two and three times that step.

The two rails are sliced side by side in the same cycle. A sample strobe marks the cycles that carry data. The result is registered, so the output strobe follows the input strobe by one clock. Between strobes the output buses keep their last decision.

Each decision is placed in signed-magnitude form at the top of a wider output lane. The bits below it are held at zero, so that other signals can be merged into that lane later.

Top module: `soft_slicer`

## Requirements
- R1: During reset `soft_vld` is 0 and both output buses are all zeros.
- R2: `soft_vld` equals `samp_vld` delayed by exactly one clock.
- R3: Bit OUT_W-1 of each output bus is 1 when the sampled rail value (two's complement) is negative, and 0 when it is zero or positive.
- R4: Bits OUT_W-2 down to OUT_W-3 of each bus hold the confidence. The confidence is the number of levels (0 to 3) that the absolute sample value reaches. With a step of 0 every level is 0, so the confidence is 3.
- R5: A sample whose absolute value equals a level counts as reaching that level.
- R6: The step is clamped to full scale, which is 2^(SAMPLE_W-1). The 2x and 3x levels saturate at full scale and never wrap. Any step at or above full scale puts all three levels at full scale.
- R7: The in-phase and quadrature rails are decided independently from their own samples. They use the same step.
- R8: The OUT_W-3 least significant bits of each output bus are always 0.
- R9: In a cycle where `samp_vld` is 0, the output buses keep their previous values, whatever the sample and step inputs do.
- R10: The most negative sample has absolute value equal to full scale, so it reaches every saturated level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_vld | input | 1 | Sample strobe |
| i_samp | input | SAMPLE_W | In-phase sample, two's complement |
| q_samp | input | SAMPLE_W | Quadrature sample, two's complement |
| step_thr | input | THR_W | Programmed step value, unsigned |
| soft_vld | output | 1 | Decision strobe, one clock after `samp_vld` |
| i_soft | output | OUT_W | In-phase decision lane: sign, confidence, zero padding |
| q_soft | output | OUT_W | Quadrature decision lane: sign, confidence, zero padding |

## Verification
Sweeps with a moderate step separate the four confidence bins. Samples placed exactly on a level, and one below it, show whether the comparison is inclusive. Steps of 0, of 200 (where only the 3x level saturates), and above full scale show whether the level arithmetic saturates rather than wraps. The most negative sample shows whether the absolute value is formed without loss. Rails given opposite signs and magnitudes, followed by strobe-low cycles with changed inputs, show cross-rail leakage and whether the output is held.

// File: rtl/soft_slice_pkg.sv
package soft_slice_pkg;
   localparam int LEVELS = 3;
   localparam int CONF_W = $clog2(LEVELS + 1);

   typedef struct packed {
      logic              neg;
      logic [CONF_W-1:0] conf;
   } soft_dec_t;

   localparam int DEC_W = $bits(soft_dec_t);
endpackage

// File: rtl/ss_level_gen.sv
module ss_level_gen
   import soft_slice_pkg::*;
#(
   parameter int SAMPLE_W = 10,
   parameter int THR_W    = 10
) (
   input  logic [THR_W-1:0]                 step_thr,
   output logic [LEVELS-1:0][SAMPLE_W-1:0]  levels
);
   localparam int MAG_W = SAMPLE_W;
   localparam int WIDE  = ((THR_W > MAG_W) ? THR_W : MAG_W) + 3;
   localparam logic [WIDE-1:0] FULL = WIDE'(1) << (SAMPLE_W - 1);

   logic [WIDE-1:0] step_ext;
   logic [WIDE-1:0] step_clamped;

   always_comb begin
      step_ext     = WIDE'(step_thr);
      step_clamped = (step_ext > FULL) ? FULL : step_ext;
   end

   for (genvar k = 0; k < LEVELS; k++) begin : g_level
      logic [WIDE-1:0] product;
      always_comb begin
         product   = step_clamped * WIDE'(k + 1);
         levels[k] = (product > FULL) ? FULL[MAG_W-1:0] : product[MAG_W-1:0];
      end
   end
endmodule

// File: rtl/ss_rail_slicer.sv
module ss_rail_slicer
   import soft_slice_pkg::*;
#(
   parameter int SAMPLE_W    = 10,
   parameter int COUNT_STYLE = 0
) (
   input  logic [SAMPLE_W-1:0]              samp,
   input  logic [LEVELS-1:0][SAMPLE_W-1:0]  levels,
   output soft_dec_t                        dec
);
   logic [SAMPLE_W-1:0] magnitude;
   logic [LEVELS-1:0]   hits;
   logic [CONF_W-1:0]   conf;

   always_comb begin
      magnitude = samp[SAMPLE_W-1] ? (~samp + SAMPLE_W'(1)) : samp;
   end

   for (genvar k = 0; k < LEVELS; k++) begin : g_cmp
      assign hits[k] = (magnitude >= levels[k]);
   end

   if (COUNT_STYLE == 0) begin : g_adder
      always_comb begin
         conf = '0;
         for (int k = 0; k < LEVELS; k++) begin
            conf = conf + CONF_W'(hits[k]);
         end
      end
   end else begin : g_thermo
      always_comb begin
         conf = '0;
         for (int k = 0; k < LEVELS; k++) begin
            if (hits[k]) conf = CONF_W'(k + 1);
         end
      end
   end

   always_comb begin
      dec.neg  = samp[SAMPLE_W-1];
      dec.conf = conf;
   end
endmodule

// File: rtl/ss_out_pack.sv
module ss_out_pack
   import soft_slice_pkg::*;
#(
   parameter int OUT_W = 8
) (
   input  soft_dec_t        dec,
   output logic [OUT_W-1:0] lane
);
   localparam int PAD_W = OUT_W - DEC_W;

   if (PAD_W == 0) begin : g_exact
      assign lane = dec;
   end else begin : g_padded
      assign lane = {dec, {PAD_W{1'b0}}};
   end
endmodule

// File: rtl/soft_slicer.sv
module soft_slicer
   import soft_slice_pkg::*;
#(
   parameter int SAMPLE_W    = 10,
   parameter int THR_W       = 10,
   parameter int OUT_W       = 8,
   parameter int COUNT_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                samp_vld,
   input  logic [SAMPLE_W-1:0] i_samp,
   input  logic [SAMPLE_W-1:0] q_samp,
   input  logic [THR_W-1:0]    step_thr,
   output logic                soft_vld,
   output logic [OUT_W-1:0]    i_soft,
   output logic [OUT_W-1:0]    q_soft
);
   localparam int RAILS = 2;

   if (SAMPLE_W < 2) begin : g_bad_sample_w
      $error("soft_slicer: SAMPLE_W must be at least 2");
   end
   if (THR_W < 1) begin : g_bad_thr_w
      $error("soft_slicer: THR_W must be at least 1");
   end
   if (OUT_W < DEC_W) begin : g_bad_out_w
      $error("soft_slicer: OUT_W must hold the decision field");
   end
   if (COUNT_STYLE != 0 && COUNT_STYLE != 1) begin : g_bad_style
      $error("soft_slicer: COUNT_STYLE must be 0 or 1");
   end

   logic [LEVELS-1:0][SAMPLE_W-1:0] levels;
   logic [RAILS-1:0][SAMPLE_W-1:0]  rail_in;
   logic [RAILS-1:0][OUT_W-1:0]     rail_lane;
   logic [RAILS-1:0][OUT_W-1:0]     rail_q;
   logic                            vld_q;

   assign rail_in[0] = i_samp;
   assign rail_in[1] = q_samp;

   ss_level_gen #(
      .SAMPLE_W (SAMPLE_W),
      .THR_W    (THR_W)
   ) u_levels (
      .step_thr (step_thr),
      .levels   (levels)
   );

   for (genvar r = 0; r < RAILS; r++) begin : g_rail
      soft_dec_t dec;

      ss_rail_slicer #(
         .SAMPLE_W    (SAMPLE_W),
         .COUNT_STYLE (COUNT_STYLE)
      ) u_slice (
         .samp   (rail_in[r]),
         .levels (levels),
         .dec    (dec)
      );

      ss_out_pack #(
         .OUT_W (OUT_W)
      ) u_pack (
         .dec  (dec),
         .lane (rail_lane[r])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rail_q[r] <= '0;
         end else if (samp_vld) begin
            rail_q[r] <= rail_lane[r];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else begin
         vld_q <= samp_vld;
      end
   end

   assign soft_vld = vld_q;
   assign i_soft   = rail_q[0];
   assign q_soft   = rail_q[1];
endmodule

// File: rtl/soft_slicer_chk.sv
module soft_slicer_chk #(
   parameter int SAMPLE_W = 10,
   parameter int THR_W    = 10,
   parameter int OUT_W    = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                samp_vld,
   input logic [SAMPLE_W-1:0] i_samp,
   input logic [SAMPLE_W-1:0] q_samp,
   input logic [THR_W-1:0]    step_thr,
   input logic                soft_vld,
   input logic [OUT_W-1:0]    i_soft,
   input logic [OUT_W-1:0]    q_soft
);
   localparam logic [SAMPLE_W-1:0] MOST_NEG = SAMPLE_W'(1) << (SAMPLE_W - 1);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> soft_vld == $past(samp_vld));

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(samp_vld)) |-> ($stable(i_soft) && $stable(q_soft)));

   assert_sign_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(samp_vld)) |->
         (i_soft[OUT_W-1] == $past(i_samp[SAMPLE_W-1]) &&
          q_soft[OUT_W-1] == $past(q_samp[SAMPLE_W-1])));

   assert_zero_step_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(samp_vld) && $past(step_thr) == '0) |->
         (i_soft[OUT_W-2 -: 2] == 2'd3 && q_soft[OUT_W-2 -: 2] == 2'd3));

   assert_zero_sample_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(samp_vld) && $past(i_samp) == '0 && $past(step_thr) != '0) |->
         i_soft[OUT_W-2 -: 2] == 2'd0);

   assert_most_neg_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(samp_vld) && $past(q_samp) == MOST_NEG) |->
         q_soft[OUT_W-2 -: 2] == 2'd3);

   if (OUT_W > 3) begin : g_pad_chk
      assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (i_soft[OUT_W-4:0] == '0) && (q_soft[OUT_W-4:0] == '0));
   end
endmodule

bind soft_slicer soft_slicer_chk #(
   .SAMPLE_W (SAMPLE_W),
   .THR_W    (THR_W),
   .OUT_W    (OUT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .samp_vld (samp_vld),
   .i_samp   (i_samp),
   .q_samp   (q_samp),
   .step_thr (step_thr),
   .soft_vld (soft_vld),
   .i_soft   (i_soft),
   .q_soft   (q_soft)
);

// File: tb/soft_slicer_test.sv
module soft_slicer_test;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 10;
   localparam int TW = 10;
   localparam int OW = 8;
   localparam int FS = 1 << (SW - 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          samp_vld = 1'b0;
   logic [SW-1:0] i_samp = '0;
   logic [SW-1:0] q_samp = '0;
   logic [TW-1:0] step_thr = '0;
   logic          soft_vld;
   logic [OW-1:0] i_soft;
   logic [OW-1:0] q_soft;

   int tests = 0;
   int fails = 0;
   logic [OW-1:0] exp_i = '0;
   logic [OW-1:0] exp_q = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   soft_slicer #(.SAMPLE_W(SW), .THR_W(TW), .OUT_W(OW)) uut (
      .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld),
      .i_samp(i_samp), .q_samp(q_samp), .step_thr(step_thr),
      .soft_vld(soft_vld), .i_soft(i_soft), .q_soft(q_soft)
   );

   function automatic int min2(int a, int b);
      return (a < b) ? a : b;
   endfunction

   function automatic logic [OW-1:0] model(int s, int thr);
      logic [OW-1:0] b;
      int t, a, m;
      t = min2(thr, FS);
      a = (s < 0) ? -s : s;
      m = 0;
      if (a >= t)               m++;
      if (a >= min2(2 * t, FS)) m++;
      if (a >= min2(3 * t, FS)) m++;
      b = '0;
      b[OW-1] = (s < 0);
      b[OW-2 -: 2] = 2'(m);
      return b;
   endfunction

   task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
   task automatic step(string tag, logic v, int i, int q, int thr);
      samp_vld = v;
      i_samp   = SW'(i);
      q_samp   = SW'(q);
      step_thr = TW'(thr);
      if (v) begin
         exp_i = model(i, thr);
         exp_q = model(q, thr);
      end
      @(posedge clk);
      @(negedge clk);
      check({tag, " R2 valid"}, OW'(soft_vld), OW'(v));
      check({tag, " i lane"}, i_soft, exp_i);
      check({tag, " q lane"}, q_soft, exp_q);
      check({tag, " R8 pad"}, OW'(i_soft[OW-4:0] | q_soft[OW-4:0]), '0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 valid in reset", OW'(soft_vld), '0);
      check("R1 i in reset", i_soft, '0);
      check("R1 q in reset", q_soft, '0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_bins();
      // R3/R4 confidence bins and sign, step 100 -> levels 100/200/300
      step("R3/R4 zero", 1, 0, 50, 100);
      step("R3/R4 bin1", 1, 150, -150, 100);
      step("R3/R4 bin2", 1, 250, -99, 100);
      step("R3/R4 bin3", 1, 350, -400, 100);
   endtask

   task automatic t_equal();
      step("R5 on level1", 1, 100, -100, 100);
      step("R5 on level2", 1, 200, 199, 100);
      step("R5 on level3", 1, -300, 299, 100);
   endtask

   task automatic t_saturate();
      step("R6 step200 2x", 1, 399, 400, 200);
      step("R6/R10 step200 top", 1, 511, -512, 200);
      step("R6 step700 clamp", 1, 511, -512, 700);
      step("R6 step max", 1, 0, -511, 1023);
      step("R4 step zero", 1, 0, -1, 0);
      step("R10 most neg step fs", 1, -512, -512, FS);
   endtask

   task automatic t_indep();
      step("R7 i hi q lo", 1, 350, -50, 100);
      step("R7 i lo q hi", 1, -50, 350, 100);
   endtask

   task automatic t_hold();
      step("R9 load", 1, -250, 120, 100);
      step("R9 idle a", 0, 500, -500, 1);
      step("R9 idle b", 0, 0, 0, 0);
      step("R9 reload", 1, 1, 2, 1);
   endtask

   task automatic t_strobe();
      for (int k = 0; k < 6; k++) begin
         step("R2 pattern", logic'(k % 3 == 0), k * 40, -k * 40, 60);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_bins();
      t_equal();
      t_saturate();
      t_indep();
      t_hold();
      t_strobe();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule